// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Block

This block is a 32-bit general-purpose I/O controller on a simple register bus. The bus has single-cycle read and write strobes, a byte offset and 32-bit data. Software sees three storage registers:

- a pin level register that holds the values driven out;
- a direction register that marks which pins are outputs;
- an auxiliary word with no side effects.

Level bits are never written directly. A word written to the set offset ORs bits in, and a word written to the clear offset removes them. Each of these writes is gated as a whole: it takes effect only if the written mask shares at least one 1 bit with the direction register. When the gate passes, every 1 bit of the mask is applied, including bits of pins configured as inputs.

The pins are driven as follows:

- the output-enable vector is the direction register;
- each pin output is the level bit masked by its direction bit.

The block flags two kinds of error, each as a one-cycle pulse:

- a set or clear write that fails the gate;
- any access to an offset that the block does not decode.

Three edge-control offsets are decoded and accept writes, but the writes have no effect. The eight low-pin interrupt lines and the shared high-pin interrupt line are held low.

Top module: `gpio_regblock`

## Requirements
- R1: After reset the level, direction and auxiliary registers are zero, and so are `pinOut`, `pinOe`, `busRdata`, `badAccess` and `writeRejected`.
- R2: A read strobe returns the addressed register on `busRdata` in the cycle after the strobe:
  - byte offset 0x00 returns the level register;
  - 0x04 returns the direction register;
  - 0x20 returns the auxiliary register.
  In any cycle that does not follow a read strobe, `busRdata` is zero.
- R3: A read of any other offset (including offsets not a multiple of 4) returns zero and pulses `badAccess` in the cycle after the strobe.
- R4: A write to 0x04 loads the full 32-bit data into the direction register. `pinOe` equals the direction register at all times.
- R5: A write to 0x08 whose data ANDed with the direction register is nonzero ORs every 1 bit of the data into the level register, including bits whose direction bit is 0.
- R6: A write to 0x0C whose data ANDed with the direction register is nonzero clears every level bit where the data holds a 1.
- R7: A write to 0x08 or 0x0C whose data shares no 1 bit with the direction register, zero data included, leaves the level register unchanged. It pulses `writeRejected` in the cycle after the strobe.
- R8: Writes to 0x10, 0x14 and 0x18 change no register and raise neither flag.
- R9: A write to 0x20 loads the auxiliary register. A write to any offset other than 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 or 0x20 changes nothing and pulses `badAccess` in the cycle after the strobe.
- R10: `pinOut` equals the level register ANDed with the direction register.
- R11: `irqLow` (8 bits) and `irqHigh` stay 0.
- R12: `badAccess` and `writeRejected` are each high only in the cycle after the offending strobe, never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| busRead | input | 1 | Read strobe, one cycle |
| busWrite | input | 1 | Write strobe, one cycle |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after the read strobe |
| badAccess | output | 1 | Pulse: access to an undecoded offset |
| writeRejected | output | 1 | Pulse: set or clear mask missed every output pin |
| pinOut | output | 32 | Pin output values |
| pinOe | output | 32 | Pin output enables |
| irqLow | output | 8 | Low-pin interrupt lines, held low |
| irqHigh | output | 1 | Shared high-pin interrupt line, held low |

## Verification
The bench targets the all-or-nothing gate on set and clear writes:

- A mask that touches one output pin and several input pins must land in full. A design that masked the data by direction would leave those input-pin level bits clear.
- A mask that touches only input pins, or a zero mask, must be refused with a pulse. A design that applied it anyway would move the level register.
- Unaligned offsets and reads of write-only offsets must report a bad access. A decoder that ignored the low address bits, or shared one table for reads and writes, would return register data instead of zero.
- The edge-control writes must stay silent and leave every register as it was.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_LEVEL = 2'd1,
    RD_DIR   = 2'd2,
    RD_AUX   = 2'd3
  } rdSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic   ldDir;
    logic   ldAux;
    logic   doSet;
    logic   doClr;
    rdSel_e rdSel;
  } gpioStrobe_t;

  // Byte offsets of the register map
  localparam int OFS_LEVEL = 'h00;
  localparam int OFS_DIR   = 'h04;
  localparam int OFS_SET   = 'h08;
  localparam int OFS_CLR   = 'h0C;
  localparam int OFS_EDGR  = 'h10;
  localparam int OFS_EDGF  = 'h14;
  localparam int OFS_EDGS  = 'h18;
  localparam int OFS_AUX   = 'h20;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              overlapHit,
  output gpioStrobe_t       strb,
  output logic              badAccess,
  output logic              writeRejected
);

  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFS_LEVEL);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_EDGR  = ADDR_W'(OFS_EDGR);
  localparam logic [ADDR_W-1:0] A_EDGF  = ADDR_W'(OFS_EDGF);
  localparam logic [ADDR_W-1:0] A_EDGS  = ADDR_W'(OFS_EDGS);
  localparam logic [ADDR_W-1:0] A_AUX   = ADDR_W'(OFS_AUX);

  logic   rdKnown;
  rdSel_e rdDec;
  logic   wrKnown;
  logic   wrSet;
  logic   wrClr;
  logic   wrDir;
  logic   wrAux;
  logic   badNext;
  logic   rejNext;

  // Read decode
  always_comb begin
    rdKnown = 1'b1;
    rdDec   = RD_NONE;
    unique case (busAddr)
      A_LEVEL: rdDec = RD_LEVEL;
      A_DIR:   rdDec = RD_DIR;
      A_AUX:   rdDec = RD_AUX;
      default: rdKnown = 1'b0;
    endcase
  end

  // Write decode
  always_comb begin
    wrKnown = 1'b1;
    wrSet   = 1'b0;
    wrClr   = 1'b0;
    wrDir   = 1'b0;
    wrAux   = 1'b0;
    unique case (busAddr)
      A_DIR:                  wrDir = 1'b1;
      A_SET:                  wrSet = 1'b1;
      A_CLR:                  wrClr = 1'b1;
      A_EDGR, A_EDGF, A_EDGS: wrKnown = 1'b1;
      A_AUX:                  wrAux = 1'b1;
      default:                wrKnown = 1'b0;
    endcase
  end

  always_comb begin
    strb.ldDir = busWrite && wrDir;
    strb.ldAux = busWrite && wrAux;
    strb.doSet = busWrite && wrSet && overlapHit;
    strb.doClr = busWrite && wrClr && overlapHit;
    strb.rdSel = busRead ? rdDec : RD_NONE;
  end

  assign badNext = (busRead && !rdKnown) || (busWrite && !wrKnown);
  assign rejNext = busWrite && (wrSet || wrClr) && !overlapHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      badAccess     <= 1'b0;
      writeRejected <= 1'b0;
    end else begin
      badAccess     <= badNext;
      writeRejected <= rejNext;
    end
  end

  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.doSet && strb.doClr)) else $error("set and clear together"); // R6

  AST_REJ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    writeRejected |-> $past(busWrite)) else $error("reject without write"); // R7

  AST_BAD_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    badAccess |-> $past(busRead || busWrite)) else $error("bad without access"); // R3

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpioStrobe_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic              overlapHit,
  output logic [DATA_W-1:0] levelQ,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe
);

  logic [DATA_W-1:0] dirQ;
  logic [DATA_W-1:0] auxQ;
  logic [DATA_W-1:0] levelNext;
  logic [DATA_W-1:0] rdNext;

  assign overlapHit = |(busWdata & dirQ);

  always_comb begin
    levelNext = levelQ;
    if (strb.doSet) levelNext = levelQ | busWdata;
    if (strb.doClr) levelNext = levelQ & ~busWdata;
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_LEVEL: rdNext = levelQ;
      RD_DIR:   rdNext = dirQ;
      RD_AUX:   rdNext = auxQ;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ   <= '0;
      dirQ     <= '0;
      auxQ     <= '0;
      busRdata <= '0;
    end else begin
      levelQ   <= levelNext;
      busRdata <= rdNext;
      if (strb.ldDir) dirQ <= busWdata;
      if (strb.ldAux) auxQ <= busWdata;
    end
  end

  // Per-pin drive
  for (genvar i = 0; i < DATA_W; i++) begin : g_pin
    assign pinOe[i]  = dirQ[i];
    assign pinOut[i] = levelQ[i] & dirQ[i];
  end

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldDir |=> pinOe == $past(busWdata)) else $error("dir load"); // R4

  AST_SET_MONO: assert property (@(posedge clk) disable iff (!rstN)
    strb.doSet |=> (levelQ & $past(busWdata)) == $past(busWdata)) else $error("set"); // R5

  AST_CLR_MONO: assert property (@(posedge clk) disable iff (!rstN)
    strb.doClr |=> (levelQ & $past(busWdata)) == '0) else $error("clear"); // R6

  AST_AUX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ldAux && strb.rdSel == RD_NONE) |=> $stable(levelQ) && $stable(pinOe))
    else $error("aux side effect"); // R9

endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
  import gpio_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int IRQ_LOW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              badAccess,
  output logic              writeRejected,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe,
  output logic [IRQ_LOW-1:0] irqLow,
  output logic              irqHigh
);

  gpioStrobe_t       strb;
  logic              overlapHit;
  logic [DATA_W-1:0] levelQ;

  gpio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .busRead      (busRead),
    .busWrite     (busWrite),
    .busAddr      (busAddr),
    .overlapHit   (overlapHit),
    .strb         (strb),
    .badAccess    (badAccess),
    .writeRejected(writeRejected)
  );

  gpio_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWdata  (busWdata),
    .overlapHit(overlapHit),
    .levelQ    (levelQ),
    .busRdata  (busRdata),
    .pinOut    (pinOut),
    .pinOe     (pinOe)
  );

  assign irqLow  = '0;
  assign irqHigh = 1'b0;

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    writeRejected |-> $stable(levelQ)) else $error("rejected write moved level"); // R7

  AST_PIN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & ~pinOe) == '0) else $error("pin driven while input"); // R10

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(badAccess && writeRejected)) else $error("both flags"); // R12

endmodule

// File: tb/gpio_regblock_bench.sv
module gpio_regblock_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        badAccess;
  logic        writeRejected;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic [7:0]  irqLow;
  logic        irqHigh;

  gpio_regblock u_gpio_regblock (
    .clk(clk), .rstN(rstN), .busRead(busRead), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .badAccess(badAccess), .writeRejected(writeRejected),
    .pinOut(pinOut), .pinOe(pinOe), .irqLow(irqLow), .irqHigh(irqHigh)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // Behavioural reference model
  logic [31:0] mLevel, mDir, mAux, eRd;
  logic        eBad, eRej;

  always @(posedge clk) begin
    if (!rstN) begin
      mLevel = 0; mDir = 0; mAux = 0; eRd = 0; eBad = 0; eRej = 0;
    end else begin
      eRd = 0; eBad = 0; eRej = 0;
      if (busRead) begin
        if (busAddr == 8'h00) eRd = mLevel;
        else if (busAddr == 8'h04) eRd = mDir;
        else if (busAddr == 8'h20) eRd = mAux;
        else eBad = 1;
      end
      if (busWrite) begin
        if (busAddr == 8'h04) mDir = busWdata;
        else if (busAddr == 8'h20) mAux = busWdata;
        else if (busAddr == 8'h08 || busAddr == 8'h0C) begin
          if ((busWdata & mDir) != 0) begin
            if (busAddr == 8'h08) mLevel = mLevel | busWdata;
            else mLevel = mLevel & ~busWdata;
          end else eRej = 1;
        end else if (busAddr == 8'h10 || busAddr == 8'h14 || busAddr == 8'h18) begin
          // accepted, no effect
        end else eBad = 1;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2 busRdata", busRdata, eRd);
      check("R3/R9 badAccess", {31'b0, badAccess}, {31'b0, eBad});
      check("R7 writeRejected", {31'b0, writeRejected}, {31'b0, eRej});
      check("R4 pinOe", pinOe, mDir);
      check("R10 pinOut", pinOut, mLevel & mDir);
      check("R11 irq", {23'b0, irqHigh, irqLow}, 32'b0);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRead = 1; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busRead = 0;
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    logic flagSeen;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1 pinOe", pinOe, 0);
    check("R1 pinOut", pinOut, 0);
    check("R1 busRdata", busRdata, 0);
    check("R1 flags", {30'b0, badAccess, writeRejected}, 0);
    rstN = 1;
    rd(8'h00, v); check("R1 level", v, 0);
    rd(8'h04, v); check("R1 dir", v, 0);
    rd(8'h20, v); check("R1 aux", v, 0);

    // R4: direction load
    wr(8'h04, 32'h0000_00FF);
    rd(8'h04, v); check("R4 dir readback", v, 32'h0000_00FF);
    check("R4 oe", pinOe, 32'h0000_00FF);

    // R5: set with overlap lands input-pin bits too
    wr(8'h08, 32'h0000_0F0F);
    rd(8'h00, v); check("R5 level", v, 32'h0000_0F0F);
    check("R10 pinOut", pinOut, 32'h0000_000F);

    // R7: no overlap and zero mask are rejected
    @(negedge clk); busWrite = 1; busAddr = 8'h08; busWdata = 32'hFF00_0000;
    @(negedge clk); busWrite = 0;
    check("R7 reject pulse", {31'b0, writeRejected}, 1);
    @(negedge clk);
    check("R12 pulse drops", {31'b0, writeRejected}, 0);
    wr(8'h0C, 32'h0000_0100);
    wr(8'h08, 32'h0);
    rd(8'h00, v); check("R7 level held", v, 32'h0000_0F0F);

    // R6: clear with overlap clears input-pin bit as well
    wr(8'h0C, 32'h0000_0101);
    rd(8'h00, v); check("R6 level", v, 32'h0000_0E0E);

    // R8: edge offsets silent
    flagSeen = 0;
    wr(8'h10, 32'hFFFF_FFFF); flagSeen |= badAccess | writeRejected;
    wr(8'h14, 32'hFFFF_FFFF); flagSeen |= badAccess | writeRejected;
    wr(8'h18, 32'hFFFF_FFFF); flagSeen |= badAccess | writeRejected;
    check("R8 no flag", {31'b0, flagSeen}, 0);
    rd(8'h00, v); check("R8 level", v, 32'h0000_0E0E);
    rd(8'h04, v); check("R8 dir", v, 32'h0000_00FF);

    // R9: aux write and bad writes
    wr(8'h20, 32'hDEAD_BEEF);
    rd(8'h20, v); check("R9 aux", v, 32'hDEAD_BEEF);
    @(negedge clk); busWrite = 1; busAddr = 8'h24; busWdata = 32'h1234_5678;
    @(negedge clk); busWrite = 0;
    check("R9 bad write flag", {31'b0, badAccess}, 1);
    wr(8'h06, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R9 dir unchanged", v, 32'h0000_00FF);
    rd(8'h20, v); check("R9 aux unchanged", v, 32'hDEAD_BEEF);

    // R3: reads of write-only or unaligned offsets
    @(negedge clk); busRead = 1; busAddr = 8'h08;
    @(negedge clk); busRead = 0;
    check("R3 bad read flag", {31'b0, badAccess}, 1);
    check("R3 bad read data", busRdata, 0);
    rd(8'h01, v); check("R3 unaligned", v, 0);
    rd(8'h1C, v); check("R3 hole", v, 0);

    // Mixed traffic compared every cycle against the model (R2..R12)
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      int pick;
      pick = $urandom_range(0, 11);
      case (pick)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h10; 5: a = 8'h14; 6: a = 8'h18; 7: a = 8'h20;
        8: a = 8'h08; 9: a = 8'h0C; 10: a = 8'h3C;
        default: a = 8'(($urandom_range(0, 63) * 4) + $urandom_range(0, 3));
      endcase
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d = d & 32'h0000_F00F;
      if ($urandom_range(0, 2) == 0) d = (a == 8'h04) ? (d & 32'h0F0F_0F0F) : (d & 32'hF0F0_F0F0);
      @(negedge clk);
      if ($urandom_range(0, 1) == 0) begin busWrite = 1; busWdata = d; end
      else busRead = 1;
      busAddr = a;
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
      end
      @(negedge clk);
      busWrite = 0; busRead = 0;
    end
    repeat (3) @(negedge clk);
    summary();
  end

endmodule